// File: doc/BRIEF.md
# Serial Register Access Port

This block lets an external host read and write a small bank of 8-bit registers over a four-wire synchronous serial link. Each transaction is framed by an active-low chip select and carries exactly two bytes. The first byte is a command that gives the direction, the register index and a channel field. The second byte is the write data, or, for a read, the slot in which the register contents are shifted back. All serial inputs are brought into the system clock domain through synchronizer chains. Every action is then taken on the system clock, so the serial clock must run several times slower than the system clock.

Written data leaves on a one-cycle write port (`reg_wr_en` acts as a valid strobe). The port has no ready signal, so the register file must accept on every cycle. For a read, the block presents the index on `reg_rd_addr` and samples `reg_rd_data` once the command byte is complete. In the same cycle it pulses `reg_rd_strobe`, so that registers which clear when read can react.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, `spi_miso`, `reg_wr_en` and `reg_rd_strobe` are all low.
- R2: Command byte layout: bit 7 set means read and clear means write; bits 6:3 give the register index; bits 2:1 give the channel; bit 0 is ignored. One transaction never both writes and strobes.
- R3: A write whose channel field is 00 produces exactly one single-cycle `reg_wr_en` pulse after the 16th rising serial clock edge. The index goes on `reg_wr_addr` and the second byte on `reg_wr_data`. Both bytes arrive MSB first, sampled on rising edges of the serial clock.
- R4: A read whose channel field is 00 samples `reg_rd_data` at `reg_rd_addr` once the command byte is complete. In that cycle it emits a single-cycle `reg_rd_strobe`. The value then leaves on `spi_miso` MSB first: each bit is valid from the falling edge after rising edge 8+k until the next rising edge.
- R5: A transaction with a non-zero channel field writes nothing and gives no strobe. A read with a non-zero channel returns 0x00.
- R6: If chip select rises before the 16th rising edge, the transaction is discarded and no write takes place.
- R7: `spi_miso` is low while chip select is high, during the command byte, and throughout write transactions.
- R8: Serial clock edges beyond the 16th are ignored. The data-in bits sent during a read never cause a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_csn | input | 1 | Active-low transaction frame |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| reg_wr_en | output | 1 | One-cycle write valid |
| reg_wr_addr | output | 4 | Write register index |
| reg_wr_data | output | 8 | Write data |
| reg_rd_addr | output | 4 | Read register index |
| reg_rd_data | input | 8 | Read data from register file at `reg_rd_addr` |
| reg_rd_strobe | output | 1 | One-cycle read side-effect strobe |

## Verification
The checks assume that each serial clock level lasts well beyond the synchronizer depth plus two system cycles. They also assume that chip select stays high for several system cycles between frames, so that the output-idle property can look a fixed number of cycles back. The bench drives every serial edge eight system clocks apart and holds chip select idle for ten cycles between transactions. It keeps chip select high throughout reset, so every property sees a quiet line from its first sampled edge.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int ADDR_W = 4;
  localparam int CMD_W  = 8;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] idx;
    logic [1:0]        ch;
    logic              spare;
  } spi_cmd_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_reg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              csn_s,
  input  logic              mosi_s,
  output logic              cmd_done,
  output spi_cmd_t          cmd,
  output logic              word_done,
  output logic [DATA_W-1:0] rx_word,
  output logic              data_phase,
  output logic              sck_fall
);
  localparam int TOTAL = CMD_W + DATA_W;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam int SH_W  = (DATA_W > CMD_W) ? DATA_W : CMD_W;

  logic             sck_q;
  logic             sck_rise;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  sh;
  logic             counting;

  assign sck_rise   = sck_s & ~sck_q;
  assign sck_fall   = ~sck_s & sck_q;
  assign counting   = ~csn_s & sck_rise & (cnt < CNT_W'(TOTAL));
  assign data_phase = cnt >= CNT_W'(CMD_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (csn_s) begin
      cnt <= '0;
      sh  <= '0;
    end else if (counting) begin
      cnt <= cnt + 1'b1;
      sh  <= {sh[SH_W-2:0], mosi_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_done  <= 1'b0;
      word_done <= 1'b0;
      cmd       <= '0;
      rx_word   <= '0;
    end else begin
      cmd_done  <= counting && (cnt == CNT_W'(CMD_W - 1));
      word_done <= counting && (cnt == CNT_W'(TOTAL - 1));
      if (counting && (cnt == CNT_W'(CMD_W - 1)))
        cmd <= spi_cmd_t'({sh[CMD_W-2:0], mosi_s});
      if (counting && (cnt == CNT_W'(TOTAL - 1)))
        rx_word <= {sh[DATA_W-2:0], mosi_s};
    end
  end
endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  output logic              miso
);
  logic [DATA_W-1:0] tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx   <= '0;
      miso <= 1'b0;
    end else if (clear) begin
      tx   <= '0;
      miso <= 1'b0;
    end else if (load) begin
      tx <= load_val;
    end else if (shift) begin
      miso <= tx[DATA_W-1];
      tx   <= {tx[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic [ADDR_W-1:0] reg_rd_addr,
  input  logic [DATA_W-1:0] reg_rd_data,
  output logic              reg_rd_strobe
);
  logic              sck_s, csn_s, mosi_s;
  logic              cmd_done, word_done, data_phase, sck_fall;
  logic [DATA_W-1:0] rx_word;
  spi_cmd_t          cmd;
  logic              ch_ok;

  spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_sck, spi_csn, spi_mosi}),
    .q     ({sck_s, csn_s, mosi_s})
  );

  spi_bit_engine #(.DATA_W(DATA_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_s      (sck_s),
    .csn_s      (csn_s),
    .mosi_s     (mosi_s),
    .cmd_done   (cmd_done),
    .cmd        (cmd),
    .word_done  (word_done),
    .rx_word    (rx_word),
    .data_phase (data_phase),
    .sck_fall   (sck_fall)
  );

  assign ch_ok = (cmd.ch == 2'b00);

  assign reg_wr_en     = word_done & ~cmd.rd & ch_ok;
  assign reg_wr_addr   = cmd.idx;
  assign reg_wr_data   = rx_word;
  assign reg_rd_addr   = cmd.idx;
  assign reg_rd_strobe = cmd_done & cmd.rd & ch_ok;

  spi_tx_shifter #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (csn_s),
    .load     (cmd_done & cmd.rd),
    .load_val (ch_ok ? reg_rd_data : '0),
    .shift    (sck_fall & data_phase & cmd.rd),
    .miso     (spi_miso)
  );
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_csn,
  input logic spi_miso,
  input logic reg_wr_en,
  input logic reg_rd_strobe
);
  AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en); // R3

  AST_STROBE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_strobe |=> !reg_rd_strobe); // R4

  AST_NO_WR_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_strobe)); // R2

  AST_MISO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3)
     && $past(spi_csn, 4)) |-> !spi_miso); // R7
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .spi_csn       (spi_csn),
  .spi_miso      (spi_miso),
  .reg_wr_en     (reg_wr_en),
  .reg_rd_strobe (reg_rd_strobe)
);

// File: tb/spi_reg_slave_test.sv
module spi_reg_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int NVEC = 11;

  // {cmd, din, expected readback, expected write, expected strobe}
  localparam logic [25:0] VEC [NVEC] = '{
    {8'h18, 8'h5A, 8'h00, 1'b1, 1'b0},
    {8'h98, 8'hFF, 8'h5A, 1'b0, 1'b1},
    {8'h78, 8'hC3, 8'h00, 1'b1, 1'b0},
    {8'hF8, 8'h00, 8'hC3, 1'b0, 1'b1},
    {8'h00, 8'h81, 8'h00, 1'b1, 1'b0},
    {8'h80, 8'h55, 8'h81, 1'b0, 1'b1},
    {8'h1A, 8'hFF, 8'h00, 1'b0, 1'b0},
    {8'h98, 8'h00, 8'h5A, 1'b0, 1'b1},
    {8'h9C, 8'h00, 8'h00, 1'b0, 1'b0},
    {8'h19, 8'h3C, 8'h00, 1'b1, 1'b0},
    {8'h99, 8'hA5, 8'h3C, 1'b0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b0;
  logic       spi_csn = 1'b1;
  logic       spi_mosi = 1'b0;
  logic       spi_miso;
  logic       reg_wr_en;
  logic [3:0] reg_wr_addr;
  logic [7:0] reg_wr_data;
  logic [3:0] reg_rd_addr;
  logic [7:0] reg_rd_data;
  logic       reg_rd_strobe;

  logic [7:0] model [16];
  int         wr_seen = 0;
  int         st_seen = 0;
  logic [3:0] last_wa = '0;
  logic [7:0] last_wd = '0;
  logic [3:0] last_sa = '0;
  int         errors = 0;
  int         checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_reg_slave uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .spi_sck       (spi_sck),
    .spi_csn       (spi_csn),
    .spi_mosi      (spi_mosi),
    .spi_miso      (spi_miso),
    .reg_wr_en     (reg_wr_en),
    .reg_wr_addr   (reg_wr_addr),
    .reg_wr_data   (reg_wr_data),
    .reg_rd_addr   (reg_rd_addr),
    .reg_rd_data   (reg_rd_data),
    .reg_rd_strobe (reg_rd_strobe)
  );

  assign reg_rd_data = model[reg_rd_addr];

  initial for (int i = 0; i < 16; i++) model[i] = 8'h00;

  always @(posedge clk) begin
    if (reg_wr_en) begin
      wr_seen <= wr_seen + 1;
      last_wa <= reg_wr_addr;
      last_wd <= reg_wr_data;
      model[reg_wr_addr] <= reg_wr_data;
    end
    if (reg_rd_strobe) begin
      st_seen <= st_seen + 1;
      last_sa <= reg_rd_addr;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] c, input logic [7:0] d, input int nbits,
                      output logic [7:0] rb);
    rb = 8'h00;
    @(negedge clk);
    spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < 8) ? c[7-i] : ((i < 16) ? d[15-i] : 1'b1);
      repeat (HALF) @(negedge clk);
      if (i >= 8 && i < 16) rb[15-i] = spi_miso;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
    repeat (2*HALF) @(negedge clk);
    spi_csn = 1'b1;
    spi_mosi = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    int w0, s0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(spi_miso == 1'b0, "R1 miso", spi_miso, 0);
    chk(reg_wr_en == 1'b0, "R1 wr_en", reg_wr_en, 0);
    chk(reg_rd_strobe == 1'b0, "R1 strobe", reg_rd_strobe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Table walk: R2 R3 R4 R5 R8
    for (int v = 0; v < NVEC; v++) begin
      w0 = wr_seen;
      s0 = st_seen;
      xfer(VEC[v][25:18], VEC[v][17:10], 16, rb);
      chk((wr_seen - w0) == int'(VEC[v][1]), "R3/R5 write count", wr_seen - w0, VEC[v][1]);
      chk((st_seen - s0) == int'(VEC[v][0]), "R4/R5 strobe count", st_seen - s0, VEC[v][0]);
      chk(rb == VEC[v][9:2], "R4/R5/R7 readback", rb, VEC[v][9:2]);
      if (VEC[v][1]) begin
        chk(last_wa == VEC[v][24:21], "R2 write index", last_wa, VEC[v][24:21]);
        chk(last_wd == VEC[v][17:10], "R3 write data", last_wd, VEC[v][17:10]);
      end
      if (VEC[v][0])
        chk(last_sa == VEC[v][24:21], "R4 strobe index", last_sa, VEC[v][24:21]);
      chk(spi_miso == 1'b0, "R7 idle miso", spi_miso, 0);
    end

    // R6: abort after 12 bits of a write to register 5
    w0 = wr_seen;
    xfer(8'h28, 8'h77, 12, rb);
    chk(wr_seen == w0, "R6 aborted write", wr_seen - w0, 0);
    xfer(8'hA8, 8'h00, 16, rb);
    chk(rb == 8'h00, "R6 register untouched", rb, 0);

    // R8: 20 clock edges on a write to register 6
    w0 = wr_seen;
    xfer(8'h30, 8'h44, 20, rb);
    chk((wr_seen - w0) == 1, "R8 single write", wr_seen - w0, 1);
    chk(last_wd == 8'h44, "R8 data unaffected by extra bits", last_wd, 8'h44);
    xfer(8'hB0, 8'h00, 16, rb);
    chk(rb == 8'h44, "R8 readback", rb, 8'h44);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule